// File: doc/BRIEF.md
# Timeslice Scheduling Controller

This block decides when the running user process must give up the processor. It keeps a saturating down-counter and an enable bit as status fields, and a small on-chip run queue of process descriptors. Each descriptor is a workspace pointer and an instruction pointer. A periodic tick wears the counter down, and a timeslice is due once the counter reaches zero.

The due state has no effect by itself. It matters only when a timeslice instruction retires while timeslicing is enabled and no exception handler is running. At that point the block either raises a one-cycle trap request, if a handler is installed, or rotates the run queue. A rotation sends the current descriptor to the back of the queue and makes the front descriptor current.

Exception entry saves the counter, and the matching return restores it. An interrupted process therefore keeps the share of its slice that it had left.

Top module: `tslice_ctrl`

## Requirements
- R1: After reset the counter reads CNT_MAX (default 16), due is 0, trap request is 0, the enable bit is 0, the current descriptor is all zeros, the run queue is empty, and no exception is in progress.
- R2: A load strobe in user context pops the front descriptor into the current descriptor and reloads the counter to CNT_MAX. With an empty queue the current descriptor is unchanged, and the counter still reloads. A tick in the same cycle is ignored.
- R3: Each tick in user context, with no load or timeslice action in that cycle, lowers the counter by one. At zero the counter stays at zero. The due output is 1 exactly when the counter is 0.
- R4: A timeslice is acted on only when a timeslice instruction strobe arrives while due is 1, the enable bit is 1, and no exception is in progress or being entered. Otherwise the strobe changes nothing.
- R5: An acted-on timeslice with the trap-installed input at 1 raises the trap request for exactly the next cycle. The counter, current descriptor and queue are left unchanged.
- R6: An acted-on timeslice with no trap installed and a non-empty queue does three things. It appends the current descriptor to the back of the queue, makes the old front descriptor current, and reloads the counter to CNT_MAX. An enqueue request in that cycle is ignored.
- R7: An acted-on timeslice with no trap installed and an empty queue leaves the current descriptor as it is and reloads the counter to CNT_MAX.
- R8: Exception entry saves the counter. While the handler runs, ticks, load strobes and timeslice strobes are ignored. Exception return puts the saved value back in the counter without reloading it.
- R9: An enable write sets the enable bit to the written value at any time. No other event changes the enable bit.
- R10: An enqueue request appends its descriptor to the back of a first-in first-out queue of QDEPTH entries (default 8). A request that arrives while the queue is full is ignored.
- R11: An entry strobe that arrives while already in an exception is ignored, as is a return strobe that arrives outside one. An accepted entry strobe overrides tick, load and timeslice strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Periodic timeslice tick |
| load_i | input | 1 | Load the front process as current |
| ts_instr_i | input | 1 | Timeslice instruction retires |
| trap_inst_i | input | 1 | Timeslice trap handler installed |
| exc_enter_i | input | 1 | Exception entry |
| exc_return_i | input | 1 | Return from exception |
| en_wr_i | input | 1 | Write the enable bit |
| en_val_i | input | 1 | Value for the enable bit |
| enq_i | input | 1 | Append a descriptor to the queue |
| enq_wptr_i | input | PTR_W | Workspace pointer to append |
| enq_iptr_i | input | PTR_W | Instruction pointer to append |
| ts_due_o | output | 1 | Counter is at zero |
| trap_req_o | output | 1 | One-cycle timeslice trap request |
| ts_en_o | output | 1 | Enable bit |
| count_o | output | $clog2(CNT_MAX+1) | Counter value |
| cur_wptr_o | output | PTR_W | Workspace pointer of the current process |
| cur_iptr_o | output | PTR_W | Instruction pointer of the current process |

## Verification
Every result is a register, so a strobe applied in one cycle is seen on the outputs one clock edge later. This holds for the counter, the trap request, the enable bit and the current descriptor. The due flag is decoded from the counter register, so it follows on that same edge. The bench applies its inputs at the falling edge and lets one rising edge pass. At the next falling edge it advances its queue-based reference model by one step and compares all six outputs. In this way each prediction is checked exactly one edge after its cause, never earlier and never later.

// File: rtl/tslice_ctrl.sv
module tslice_ctrl #(
  parameter int CNT_MAX = 16,
  parameter int QDEPTH  = 8,
  parameter int PTR_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick_i,
  input  logic                             load_i,
  input  logic                             ts_instr_i,
  input  logic                             trap_inst_i,
  input  logic                             exc_enter_i,
  input  logic                             exc_return_i,
  input  logic                             en_wr_i,
  input  logic                             en_val_i,
  input  logic                             enq_i,
  input  logic [PTR_W-1:0]                 enq_wptr_i,
  input  logic [PTR_W-1:0]                 enq_iptr_i,
  output logic                             ts_due_o,
  output logic                             trap_req_o,
  output logic                             ts_en_o,
  output logic [$clog2(CNT_MAX+1)-1:0]     count_o,
  output logic [PTR_W-1:0]                 cur_wptr_o,
  output logic [PTR_W-1:0]                 cur_iptr_o
);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int IDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [CNT_W-1:0] CMAX  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] CONE  = CNT_W'(1);
  localparam logic [IDX_W-1:0] IONE  = IDX_W'(1);
  localparam logic [IDX_W:0]   LONE  = (IDX_W+1)'(1);
  localparam logic [IDX_W:0]   LFULL = (IDX_W+1)'(QDEPTH);

  logic [CNT_W-1:0] cnt, saved;
  logic             in_exc, ts_en;
  logic [PTR_W-1:0] qw [QDEPTH];
  logic [PTR_W-1:0] qi [QDEPTH];
  logic [IDX_W-1:0] head, tail;
  logic [IDX_W:0]   level;

  wire q_empty  = (level == '0);
  wire q_full   = (level == LFULL);
  wire enter    = exc_enter_i && !in_exc;
  wire leave    = exc_return_i && in_exc;
  wire user     = !in_exc && !enter;
  wire fire     = user && ts_instr_i && (cnt == '0) && ts_en;
  wire do_trap  = fire && trap_inst_i;
  wire do_swap  = fire && !trap_inst_i;
  wire do_load  = user && !fire && load_i;
  wire pop      = (do_swap || do_load) && !q_empty;
  wire push_cur = do_swap && !q_empty;
  wire push_enq = enq_i && !do_swap && !q_full;
  wire push     = push_cur || push_enq;
  wire reload   = do_swap || do_load;
  wire dec      = user && !fire && !load_i && tick_i && (cnt != '0);

  assign ts_due_o = (cnt == '0);
  assign ts_en_o  = ts_en;
  assign count_o  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= CMAX;
      saved      <= CMAX;
      in_exc     <= 1'b0;
      ts_en      <= 1'b0;
      trap_req_o <= 1'b0;
    end else begin
      trap_req_o <= do_trap;
      if (en_wr_i) ts_en <= en_val_i;
      if (enter) begin
        saved  <= cnt;
        in_exc <= 1'b1;
      end else if (leave) begin
        cnt    <= saved;
        in_exc <= 1'b0;
      end else if (reload) begin
        cnt <= CMAX;
      end else if (dec) begin
        cnt <= cnt - CONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head       <= '0;
      tail       <= '0;
      level      <= '0;
      cur_wptr_o <= '0;
      cur_iptr_o <= '0;
    end else begin
      if (pop) begin
        cur_wptr_o <= qw[head];
        cur_iptr_o <= qi[head];
        head       <= head + IONE;
      end
      if (push) tail <= tail + IONE;
      if (push && !pop)      level <= level + LONE;
      else if (pop && !push) level <= level - LONE;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      qw[tail] <= push_cur ? cur_wptr_o : enq_wptr_i;
      qi[tail] <= push_cur ? cur_iptr_o : enq_iptr_i;
    end
  end

  AST_CNT_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) cnt <= CMAX); // R3
  AST_TICK_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                      (!in_exc && !exc_enter_i && tick_i && !load_i && !ts_instr_i && cnt != '0)
                      |=> cnt == $past(cnt) - CONE); // R3
  AST_TRAP_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n)
                      trap_req_o |-> $past(ts_instr_i && trap_inst_i && ts_due_o)); // R5
  AST_TRAP_KEEPS:   assert property (@(posedge clk) disable iff (!rst_n)
                      trap_req_o |-> ts_due_o); // R5
  AST_SWAP_RELOAD:  assert property (@(posedge clk) disable iff (!rst_n)
                      (ts_instr_i && !trap_inst_i && ts_due_o && ts_en && !in_exc && !exc_enter_i)
                      |=> cnt == CMAX); // R6
  AST_EXC_FREEZE:   assert property (@(posedge clk) disable iff (!rst_n)
                      (in_exc && !exc_return_i) |=> $stable(cnt)); // R8
  AST_EN_HOLD:      assert property (@(posedge clk) disable iff (!rst_n)
                      !en_wr_i |=> $stable(ts_en)); // R9
  AST_LEVEL_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) level <= LFULL); // R10
endmodule

// File: tb/tslice_ctrl_test.sv
module tslice_ctrl_test;
  localparam int MAXC = 16;
  localparam int DEP  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, load, ts, trapi, ent, ret, enw, env, enq;
  logic [31:0] ew, ei;
  logic ts_due, trap_req, ts_en;
  logic [4:0] count;
  logic [31:0] cw, ci;

  always #4 clk = ~clk;

  tslice_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load), .ts_instr_i(ts),
    .trap_inst_i(trapi), .exc_enter_i(ent), .exc_return_i(ret), .en_wr_i(enw),
    .en_val_i(env), .enq_i(enq), .enq_wptr_i(ew), .enq_iptr_i(ei),
    .ts_due_o(ts_due), .trap_req_o(trap_req), .ts_en_o(ts_en), .count_o(count),
    .cur_wptr_o(cw), .cur_iptr_o(ci));

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  int m_cnt, m_saved;
  bit m_exc, m_en, m_trap;
  logic [63:0] m_cur;
  logic [63:0] rq[$];

  task automatic idle();
    {tick, load, ts, trapi, ent, ret, enw, env, enq} = '0;
    ew = '0; ei = '0;
  endtask

  task automatic model_reset();
    m_cnt = MAXC; m_saved = MAXC; m_exc = 0; m_en = 0; m_trap = 0;
    m_cur = '0; rq.delete();
  endtask

  task automatic model_step();
    bit enter, leave, user, fire, enq_ok;
    int old_size;
    old_size = rq.size();
    enter = ent && !m_exc;
    leave = ret && m_exc;
    user  = !m_exc && !enter;
    fire  = user && ts && (m_cnt == 0) && m_en;
    enq_ok = enq && !(fire && !trapi) && (old_size < DEP);
    m_trap = fire && trapi;
    if (enw) m_en = env;
    if (enter) begin
      m_saved = m_cnt; m_exc = 1;
    end else if (leave) begin
      m_cnt = m_saved; m_exc = 0;
    end else if (fire && !trapi) begin
      if (old_size > 0) begin
        logic [63:0] nx;
        nx = rq.pop_front();
        rq.push_back(m_cur);
        m_cur = nx;
      end
      m_cnt = MAXC;
    end else if (user && !fire && load) begin
      if (old_size > 0) m_cur = rq.pop_front();
      m_cnt = MAXC;
    end else if (user && !fire && tick && m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end
    if (enq_ok) rq.push_back({ew, ei});
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("count", 64'(count), 64'(m_cnt));
    chk("due", 64'(ts_due), 64'(m_cnt == 0));
    chk("trap", 64'(trap_req), 64'(m_trap));
    chk("enable", 64'(ts_en), 64'(m_en));
    chk("cur_wptr", 64'(cw), 64'(m_cur[63:32]));
    chk("cur_iptr", 64'(ci), 64'(m_cur[31:0]));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare();
    idle();
  endtask

  task automatic put(logic [31:0] w, logic [31:0] i);
    enq = 1; ew = w; ei = i; step();
  endtask

  initial begin
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; compare();

    tag = "R10";
    for (int k = 0; k < 3; k++) put(32'h1000 + k, 32'h2000 + k);
    tag = "R2"; load = 1; tick = 1; step();
    tag = "R3";
    for (int k = 0; k < 20; k++) begin tick = 1; step(); end
    tag = "R4"; ts = 1; step();
    tag = "R9"; enw = 1; env = 1; step();
    tag = "R5"; ts = 1; trapi = 1; step(); step();
    tag = "R6"; ts = 1; enq = 1; ew = 32'hdead; ei = 32'hbeef; step();
    tag = "R4"; ts = 1; step();
    tag = "R8";
    for (int k = 0; k < 5; k++) begin tick = 1; step(); end
    ent = 1; tick = 1; step();
    tag = "R11"; ent = 1; step();
    tag = "R8";
    for (int k = 0; k < 4; k++) begin tick = 1; ts = 1; load = 1; step(); end
    ret = 1; step();
    tag = "R11"; ret = 1; tick = 1; step();
    tag = "R10";
    for (int k = 0; k < 8; k++) put(32'h3000 + k, 32'h4000 + k);
    tag = "R6";
    for (int r = 0; r < 9; r++) begin
      for (int k = 0; k < MAXC; k++) begin tick = 1; step(); end
      ts = 1; step();
    end
    tag = "R2";
    for (int k = 0; k < 10; k++) begin load = 1; step(); end
    tag = "R7";
    for (int k = 0; k < MAXC; k++) begin tick = 1; step(); end
    ts = 1; step();
    tag = "R9"; ent = 1; step(); enw = 1; env = 0; step(); ret = 1; step();

    tag = "RND";
    for (int k = 0; k < 4000; k++) begin
      tick  = ($urandom_range(0, 1) == 0);
      load  = ($urandom_range(0, 19) == 0);
      ts    = ($urandom_range(0, 5) == 0);
      trapi = ($urandom_range(0, 1) == 0);
      ent   = ($urandom_range(0, 29) == 0);
      ret   = ($urandom_range(0, 14) == 0);
      enw   = ($urandom_range(0, 39) == 0);
      env   = ($urandom_range(0, 3) != 0);
      enq   = ($urandom_range(0, 7) == 0);
      ew    = $urandom;
      ei    = $urandom;
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule